// File: doc/BRIEF.md
# Configuration Image Integrity Checker

This block checks a memory module's configuration image while the bytes stream past it, one per valid cycle, in rising address order. A start pulse arms it. The byte at offset 2 names the image type, and that type chooses one of two integrity schemes.

In the sum scheme, an 8-bit additive checksum covers the first 63 bytes and is compared with the byte at offset 63. In the CRC scheme, a 16-bit CRC covers bytes 0 to 125 and is compared with the two-byte value at offsets 126 and 127.

When the stored check value has arrived, the block raises a one-cycle done strobe. A pass flag and an unsupported-type flag come with the strobe. A host reading the image uses a failure to fall back to safe memory settings. Fetching the bytes from the bus and acting on the verdict are left to the surrounding logic.

Top module: `cfg_image_checker`

## Requirements
- R1: After reset, done_o, pass_o and unsup_o are low. Bytes streamed before the first start pulse are ignored and produce no done strobe.
- R2: The byte taken at address 2 selects the scheme. Value 8'h04 selects the 8-bit sum scheme and value 8'h0C selects the CRC-16 scheme.
- R3: In the sum scheme, pass_o is 1 exactly when the byte at address 63 equals the sum, modulo 256, of the bytes at addresses 0 to 62.
- R4: In the CRC scheme, the CRC uses polynomial 16'h1021, an initial value of 16'h0000, no final inversion, and feeds each byte most-significant bit first over addresses 0 to 125. The result is compared with {byte at 127, byte at 126}: address 126 holds the low byte. pass_o is 1 exactly when they are equal.
- R5: done_o is high for exactly one cycle. It rises in the cycle after the deciding byte is accepted: address 63 in the sum scheme, address 127 in the CRC scheme. pass_o and unsup_o are valid from that cycle and hold until the next start pulse.
- R6: Any other type value at address 2 ends the check in the following cycle with done_o=1, pass_o=0 and unsup_o=1.
- R7: A cycle with byte_vld_i low has no effect. Bytes outside the covered range of the selected scheme do not change the verdict. After done, further bytes give no new done strobe and leave pass_o and unsup_o unchanged.
- R8: A start pulse, even in the middle of a stream, clears pass_o and unsup_o from the next cycle on, along with both accumulators. The following image is judged on its own bytes only.
- R9: A mismatch gives done_o=1 with pass_o=0 and unsup_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that arms a new check. A byte offered in the same cycle is dropped |
| byte_vld_i | input | 1 | Qualifies byte_i and addr_i |
| byte_i | input | 8 | Image byte |
| addr_i | input | 9 | Address of byte_i within the image |
| done_o | output | 1 | One-cycle strobe when the verdict is ready |
| pass_o | output | 1 | Verdict: 1 when the stored check value matches |
| unsup_o | output | 1 | Type byte was not recognised |

## Verification
Every verdict is one register stage behind the byte that decides it. For a recognised type, done_o rises in the cycle after address 63 or 127 is accepted. For an unknown type, it rises in the cycle after address 2 is accepted. A start pulse shows as cleared flags one cycle later.

The bench drives inputs on the falling edge and samples done_o on the next falling edge, before it drives the following byte. For each done strobe it records the address of the last accepted byte, so the check confirms both the one-cycle latency and the deciding address. It also counts strobes, which confirms that no second one follows once the verdict is reached.

// File: rtl/cfg_chk_pkg.sv
package cfg_chk_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } chk_state_e;

   typedef enum logic [1:0] {
      MD_NONE = 2'd0,
      MD_SUM  = 2'd1,
      MD_CRC  = 2'd2
   } chk_mode_e;

endpackage

// File: rtl/cfg_sum_acc.sv
module cfg_sum_acc #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              en_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] acc_o
);

   logic [DATA_W-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (clr_i) acc_q <= '0;
      else if (en_i)  acc_q <= acc_q + data_i;
   end

   assign acc_o = acc_q;

endmodule

// File: rtl/cfg_crc_acc.sv
module cfg_crc_acc #(
   parameter int          DATA_W    = 8,
   parameter int          CRC_W     = 16,
   parameter logic [15:0] POLY      = 16'h1021,
   parameter logic [15:0] INIT      = 16'h0000,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              en_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  crc_o
);

   localparam logic [CRC_W-1:0] POLY_W = CRC_W'(POLY);
   localparam logic [CRC_W-1:0] INIT_W = CRC_W'(INIT);
   localparam int               SHIFT  = CRC_W - DATA_W;

   function automatic logic [CRC_W-1:0] reflect(input logic [CRC_W-1:0] v);
      logic [CRC_W-1:0] r;
      for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
      return r;
   endfunction

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_nxt;

   generate
      if (MSB_FIRST) begin : g_msb
         always_comb begin
            logic [CRC_W-1:0] c;
            c = crc_q ^ ({{SHIFT{1'b0}}, data_i} << SHIFT);
            for (int b = 0; b < DATA_W; b++) begin
               if (c[CRC_W-1]) c = (c << 1) ^ POLY_W;
               else            c = c << 1;
            end
            crc_nxt = c;
         end
      end else begin : g_lsb
         localparam logic [CRC_W-1:0] RPOLY = reflect(POLY_W);
         always_comb begin
            logic [CRC_W-1:0] c;
            c = crc_q ^ {{SHIFT{1'b0}}, data_i};
            for (int b = 0; b < DATA_W; b++) begin
               if (c[0]) c = (c >> 1) ^ RPOLY;
               else      c = c >> 1;
            end
            crc_nxt = c;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= INIT_W;
      else if (clr_i) crc_q <= INIT_W;
      else if (en_i)  crc_q <= crc_nxt;
   end

   assign crc_o = crc_q;

endmodule

// File: rtl/cfg_chk_ctrl.sv
module cfg_chk_ctrl
   import cfg_chk_pkg::*;
#(
   parameter int         DATA_W    = 8,
   parameter int         ADDR_W    = 9,
   parameter int         CRC_W     = 16,
   parameter int         TYPE_ADDR = 2,
   parameter int         SUM_LAST  = 62,
   parameter int         SUM_CHK   = 63,
   parameter int         CRC_LAST  = 125,
   parameter int         CRC_LO    = 126,
   parameter int         CRC_HI    = 127,
   parameter logic [7:0] TYPE_SUM  = 8'h04,
   parameter logic [7:0] TYPE_CRC  = 8'h0C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              byte_vld_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] sum_i,
   input  logic [CRC_W-1:0]  crc_i,
   output logic              clr_o,
   output logic              sum_en_o,
   output logic              crc_en_o,
   output logic              done_o,
   output logic              pass_o,
   output logic              unsup_o
);

   localparam logic [ADDR_W-1:0] A_TYPE     = ADDR_W'(TYPE_ADDR);
   localparam logic [ADDR_W-1:0] A_SUM_LAST = ADDR_W'(SUM_LAST);
   localparam logic [ADDR_W-1:0] A_SUM_CHK  = ADDR_W'(SUM_CHK);
   localparam logic [ADDR_W-1:0] A_CRC_LAST = ADDR_W'(CRC_LAST);
   localparam logic [ADDR_W-1:0] A_CRC_LO   = ADDR_W'(CRC_LO);
   localparam logic [ADDR_W-1:0] A_CRC_HI   = ADDR_W'(CRC_HI);
   localparam logic [DATA_W-1:0] T_SUM      = DATA_W'(TYPE_SUM);
   localparam logic [DATA_W-1:0] T_CRC      = DATA_W'(TYPE_CRC);

   chk_state_e        state_q;
   chk_mode_e         mode_q;
   logic [DATA_W-1:0] lo_q;
   logic              done_q, pass_q, unsup_q;
   logic              take;

   assign take     = (state_q == ST_RUN) && byte_vld_i && !start_i;
   assign clr_o    = start_i;
   assign sum_en_o = take && (addr_i <= A_SUM_LAST);
   assign crc_en_o = take && (addr_i <= A_CRC_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= MD_NONE;
         lo_q    <= '0;
         done_q  <= 1'b0;
         pass_q  <= 1'b0;
         unsup_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            state_q <= ST_RUN;
            mode_q  <= MD_NONE;
            lo_q    <= '0;
            pass_q  <= 1'b0;
            unsup_q <= 1'b0;
         end else if (take) begin
            if (addr_i == A_TYPE) begin
               if (byte_i == T_SUM)      mode_q <= MD_SUM;
               else if (byte_i == T_CRC) mode_q <= MD_CRC;
               else begin
                  done_q  <= 1'b1;
                  unsup_q <= 1'b1;
                  state_q <= ST_FIN;
               end
            end
            if (mode_q == MD_SUM && addr_i == A_SUM_CHK) begin
               done_q  <= 1'b1;
               pass_q  <= (byte_i == sum_i);
               state_q <= ST_FIN;
            end
            if (mode_q == MD_CRC && addr_i == A_CRC_LO)
               lo_q <= byte_i;
            if (mode_q == MD_CRC && addr_i == A_CRC_HI) begin
               done_q  <= 1'b1;
               pass_q  <= ({byte_i, lo_q} == crc_i);
               state_q <= ST_FIN;
            end
         end
      end
   end

   assign done_o  = done_q;
   assign pass_o  = pass_q;
   assign unsup_o = unsup_q;

endmodule

// File: rtl/cfg_image_checker.sv
module cfg_image_checker
   import cfg_chk_pkg::*;
#(
   parameter int          DATA_W    = 8,
   parameter int          ADDR_W    = 9,
   parameter int          CRC_W     = 16,
   parameter logic [15:0] CRC_POLY  = 16'h1021,
   parameter logic [15:0] CRC_INIT  = 16'h0000,
   parameter bit          CRC_MSB   = 1'b1,
   parameter int          TYPE_ADDR = 2,
   parameter int          SUM_LAST  = 62,
   parameter int          SUM_CHK   = 63,
   parameter int          CRC_LAST  = 125,
   parameter int          CRC_LO    = 126,
   parameter int          CRC_HI    = 127,
   parameter logic [7:0]  TYPE_SUM  = 8'h04,
   parameter logic [7:0]  TYPE_CRC  = 8'h0C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              byte_vld_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              done_o,
   output logic              pass_o,
   output logic              unsup_o
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   initial begin : elab_chk
      assert (CRC_W == 2 * DATA_W)
         else $error("CRC width must be two data bytes");
      assert (SUM_CHK > SUM_LAST && TYPE_ADDR <= SUM_LAST)
         else $error("sum layout: check byte must follow covered range");
      assert (CRC_LO > CRC_LAST && CRC_HI > CRC_LO && TYPE_ADDR <= CRC_LAST)
         else $error("CRC layout: check bytes must follow covered range");
      assert (CRC_HI < ADDR_SPAN && SUM_CHK < ADDR_SPAN)
         else $error("address width too small for image layout");
   end

   logic              clr, sum_en, crc_en;
   logic [DATA_W-1:0] sum_acc;
   logic [CRC_W-1:0]  crc_acc;

   cfg_sum_acc #(.DATA_W(DATA_W)) u_sum (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr),
      .en_i   (sum_en),
      .data_i (byte_i),
      .acc_o  (sum_acc)
   );

   cfg_crc_acc #(
      .DATA_W    (DATA_W),
      .CRC_W     (CRC_W),
      .POLY      (CRC_POLY),
      .INIT      (CRC_INIT),
      .MSB_FIRST (CRC_MSB)
   ) u_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr),
      .en_i   (crc_en),
      .data_i (byte_i),
      .crc_o  (crc_acc)
   );

   cfg_chk_ctrl #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .CRC_W     (CRC_W),
      .TYPE_ADDR (TYPE_ADDR),
      .SUM_LAST  (SUM_LAST),
      .SUM_CHK   (SUM_CHK),
      .CRC_LAST  (CRC_LAST),
      .CRC_LO    (CRC_LO),
      .CRC_HI    (CRC_HI),
      .TYPE_SUM  (TYPE_SUM),
      .TYPE_CRC  (TYPE_CRC)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .byte_vld_i (byte_vld_i),
      .byte_i     (byte_i),
      .addr_i     (addr_i),
      .sum_i      (sum_acc),
      .crc_i      (crc_acc),
      .clr_o      (clr),
      .sum_en_o   (sum_en),
      .crc_en_o   (crc_en),
      .done_o     (done_o),
      .pass_o     (pass_o),
      .unsup_o    (unsup_o)
   );

endmodule

// File: rtl/cfg_image_checker_sva.sv
module cfg_image_checker_sva #(
   parameter int ADDR_W    = 9,
   parameter int TYPE_ADDR = 2,
   parameter int SUM_CHK   = 63,
   parameter int CRC_HI    = 127
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              byte_vld_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              done_o,
   input logic              pass_o,
   input logic              unsup_o
);

   localparam logic [ADDR_W-1:0] A_TYPE = ADDR_W'(TYPE_ADDR);
   localparam logic [ADDR_W-1:0] A_SUM  = ADDR_W'(SUM_CHK);
   localparam logic [ADDR_W-1:0] A_CRC  = ADDR_W'(CRC_HI);

   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_after_check_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(byte_vld_i) && !$past(start_i) &&
                  ($past(addr_i) == A_SUM || $past(addr_i) == A_CRC ||
                   $past(addr_i) == A_TYPE)));

   p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!done_o && !pass_o && !unsup_o));

   p_unsup_fails_r6: assert property (@(posedge clk) disable iff (!rst_n)
      unsup_o |-> !pass_o);

   p_unsup_at_type_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && unsup_o) |-> ($past(addr_i) == A_TYPE));

   p_result_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> (done_o || ($stable(pass_o) && $stable(unsup_o))));

endmodule

bind cfg_image_checker cfg_image_checker_sva #(
   .ADDR_W    (ADDR_W),
   .TYPE_ADDR (TYPE_ADDR),
   .SUM_CHK   (SUM_CHK),
   .CRC_HI    (CRC_HI)
) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .byte_vld_i (byte_vld_i),
   .addr_i     (addr_i),
   .done_o     (done_o),
   .pass_o     (pass_o),
   .unsup_o    (unsup_o)
);

// File: tb/tb_cfg_image_checker.sv
`timescale 1ns/1ps
module tb_cfg_image_checker;

   localparam int IMG_N = 140;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       byte_vld_i = 1'b0;
   logic [7:0] byte_i = '0;
   logic [8:0] addr_i = '0;
   logic       done_o, pass_o, unsup_o;

   cfg_image_checker dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .byte_vld_i (byte_vld_i),
      .byte_i     (byte_i),
      .addr_i     (addr_i),
      .done_o     (done_o),
      .pass_o     (pass_o),
      .unsup_o    (unsup_o)
   );

   always #10 clk = ~clk;

   int         n_tests = 0;
   int         n_fail  = 0;
   int         done_cnt;
   int         done_addr;
   int         last_addr;
   logic [7:0] img [IMG_N];

   typedef struct packed {
      logic [7:0] typ;
      logic [7:0] seed;
      logic [8:0] flip;
      logic       exp_pass;
      logic       exp_unsup;
   } vec_t;

   localparam logic [8:0] NOFLIP = 9'h1FF;
   localparam int NVEC = 13;
   localparam vec_t VEC [NVEC] = '{
      '{8'h04, 8'd3,  NOFLIP, 1'b1, 1'b0},  // R2 R3 clean sum image
      '{8'h04, 8'd11, 9'd62,  1'b0, 1'b0},  // R3 R9 last covered byte
      '{8'h04, 8'd27, 9'd63,  1'b0, 1'b0},  // R3 R9 check byte
      '{8'h04, 8'd5,  9'd100, 1'b1, 1'b0},  // R7 beyond range
      '{8'h04, 8'd19, 9'd1,   1'b0, 1'b0},  // R3 early byte
      '{8'h0C, 8'd7,  NOFLIP, 1'b1, 1'b0},  // R2 R4 clean CRC image
      '{8'h0C, 8'd13, 9'd125, 1'b0, 1'b0},  // R4 R9 last covered byte
      '{8'h0C, 8'd9,  9'd126, 1'b0, 1'b0},  // R4 low check byte
      '{8'h0C, 8'd21, 9'd127, 1'b0, 1'b0},  // R4 high check byte
      '{8'h0C, 8'd33, 9'd0,   1'b0, 1'b0},  // R4 first byte
      '{8'h0C, 8'd17, 9'd130, 1'b1, 1'b0},  // R7 beyond range
      '{8'h05, 8'd4,  NOFLIP, 1'b0, 1'b1},  // R6
      '{8'h00, 8'd6,  NOFLIP, 1'b0, 1'b1}   // R6
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic st, input logic v, input int a, input logic [7:0] d);
      @(negedge clk);
      if (done_o) begin
         done_cnt++;
         done_addr = last_addr;
      end
      start_i    = st;
      byte_vld_i = v;
      addr_i     = 9'(a);
      byte_i     = d;
      if (v && !st) last_addr = a;
   endtask

   function automatic logic [15:0] crc_ref(input int last);
      logic [15:0] c = 16'h0000;
      for (int i = 0; i <= last; i++) begin
         for (int b = 7; b >= 0; b--) begin
            logic fb;
            fb = c[15] ^ img[i][b];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
         end
      end
      return c;
   endfunction

   task automatic build(input logic [7:0] typ, input logic [7:0] seed, input logic [8:0] flip);
      logic [7:0]  s;
      logic [15:0] c;
      for (int i = 0; i < IMG_N; i++) img[i] = 8'(i * seed + (i >> 3) + 8'h5A);
      img[2] = typ;
      if (typ == 8'h04) begin
         s = '0;
         for (int i = 0; i <= 62; i++) s = s + img[i];
         img[63] = s;
      end else if (typ == 8'h0C) begin
         c = crc_ref(125);
         img[126] = c[7:0];
         img[127] = c[15:8];
      end
      if (flip != NOFLIP) img[flip] = img[flip] ^ 8'h01;
   endtask

   task automatic stream(input bit with_start, input int n, input bit gaps);
      done_cnt  = 0;
      done_addr = -1;
      last_addr = -1;
      if (with_start) drive(1'b1, 1'b0, 0, 8'h00);
      for (int i = 0; i < n; i++) begin
         drive(1'b0, 1'b1, i, img[i]);
         if (gaps) drive(1'b0, 1'b0, 63, 8'hFF);
      end
      drive(1'b0, 1'b0, 0, 8'h00);
      drive(1'b0, 1'b0, 0, 8'h00);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(done_o == 0 && pass_o == 0 && unsup_o == 0, "R1 reset outputs",
            {done_o, pass_o, unsup_o}, 0);

      // R1: a valid image with no start pulse is ignored
      build(8'h04, 8'd3, NOFLIP);
      stream(1'b0, IMG_N, 1'b0);
      check(done_cnt == 0, "R1 no done without start", done_cnt, 0);
      check(pass_o == 0, "R1 no pass without start", pass_o, 0);

      // table walk: R2 R3 R4 R5 R6 R7 R9
      for (int v = 0; v < NVEC; v++) begin
         int exp_addr;
         build(VEC[v].typ, VEC[v].seed, VEC[v].flip);
         stream(1'b1, IMG_N, 1'b0);
         exp_addr = (VEC[v].typ == 8'h04) ? 63 : (VEC[v].typ == 8'h0C) ? 127 : 2;
         check(done_cnt == 1, $sformatf("R5 single done vec%0d", v), done_cnt, 1);
         check(done_addr == exp_addr, $sformatf("R5 done timing vec%0d", v),
               done_addr, exp_addr);
         check(pass_o == VEC[v].exp_pass, $sformatf("R3/R4 verdict vec%0d", v),
               pass_o, VEC[v].exp_pass);
         check(unsup_o == VEC[v].exp_unsup, $sformatf("R6 unsup vec%0d", v),
               unsup_o, VEC[v].exp_unsup);
      end

      // R8: start clears held unsupported flag
      drive(1'b1, 1'b0, 0, 8'h00);
      @(negedge clk);
      check(unsup_o == 0 && pass_o == 0, "R8 start clears flags",
            {pass_o, unsup_o}, 0);

      // R7: idle cycles with garbage data between bytes change nothing
      build(8'h04, 8'd29, NOFLIP);
      stream(1'b1, 70, 1'b1);
      check(done_cnt == 1 && done_addr == 63, "R7 gaps done timing", done_addr, 63);
      check(pass_o == 1, "R7 gaps verdict", pass_o, 1);

      // R8: start clears a held pass
      drive(1'b1, 1'b0, 0, 8'h00);
      @(negedge clk);
      check(pass_o == 0, "R8 start clears pass", pass_o, 0);

      // R8: restart mid-stream, next image judged alone
      build(8'h0C, 8'd41, NOFLIP);
      stream(1'b1, 100, 1'b0);
      check(done_cnt == 0, "R8 partial stream no done", done_cnt, 0);
      build(8'h0C, 8'd55, NOFLIP);
      stream(1'b1, IMG_N, 1'b0);
      check(done_cnt == 1 && done_addr == 127, "R8 restart done timing", done_addr, 127);
      check(pass_o == 1 && unsup_o == 0, "R8 restart verdict", pass_o, 1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule